// File: doc/BRIEF.md
# Paired Timer Capture/Compare Channel

This block provides two timer channels that both watch one free-running counter value, which arrives on an input port. Each channel holds a value register. In compare mode a channel drives its output pin when the counter equals that value. The pin can toggle, be forced low, be forced high, or stay as it is. In capture mode a channel stores the counter into its value register when a chosen edge appears on its capture input. The edge can be rising, falling, or either. Each capture input first passes through a one-flop sampler and a programmable stability filter.

Any channel event sets that channel's sticky flag. A flag is routed either to an interrupt line or to a DMA request line, and never to both. The two channels can also work together to measure pulse width. In that paired mode both channels listen to capture input 0. Channel 0 records the first qualifying edge and channel 1 records the next qualifying edge, each channel using its own edge choice. In one-shot mode the pair then stops until it is re-armed. In continuous mode the pair starts over at once.

Counter generation and register bus access are handled elsewhere. Configuration arrives on plain input ports, and each value register can be loaded through a write strobe.

Top module: `tcc_pair`

## Requirements
- R1: After reset, both value registers are 0, and both pins, flags, interrupt lines and DMA lines are 0.
- R2: With func=2'b01 (compare), if cnt_i equals the channel value during a cycle, the pin changes at the next clock edge according to act: 2'b00 leaves it unchanged, 2'b01 toggles it, 2'b10 drives it to 0, 2'b11 drives it to 1. In every other cycle the pin holds its value.
- R3: With func=2'b10 (capture), act selects the edge: bit 0 selects rising and bit 1 selects falling, so 2'b11 captures on either edge and 2'b00 captures on none. A change on cap_i that is sampled at clock edge k, with a filter length of 0, stores the cnt_i value present before edge k+2 into the value register.
- R4: A write strobe loads wdata_i into that channel's value register at the next edge. If a capture happens in the same cycle, the capture wins.
- R5: With filter length N≥1, the sampled input must differ from the accepted level for N consecutive cycles before the new level is accepted. Shorter pulses produce no edge. Lengths 0 and 1 add no delay.
- R6: A compare match or a capture sets the channel flag at the next edge. The flag stays set until clr_i is high for that channel. If an event and a clear occur together, the event wins.
- R7: While the flag is set and ie_i is 1, irq_o is driven when dma_en_i is 0 and dma_o is driven when dma_en_i is 1. Both lines are 0 whenever ie_i is 0.
- R8: With dual_i=1, both channels capture from cap_i[0] through filter 0, and func_i and cap_i[1] are ignored. Channel 0 captures the first edge that matches act_i[0]. Channel 1 then captures the next edge that matches act_i[1]. For a high pulse of W cycles, with rise selected on channel 0 and fall on channel 1, the difference between the two captured values is W.
- R9: With cont_i=0 (one-shot), after channel 1 captures, no further paired capture happens until an arm_i pulse. With cont_i=1, channel 0 is armed again right after channel 1 captures. Both arm_i and dual_i=0 return the pair to waiting for channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Free-running counter value |
| cap_i | input | 2 | Capture inputs, one per channel |
| func_i | input | 2x2 | Per-channel function: 00 off, 01 compare, 10 capture |
| act_i | input | 2x2 | Compare action or capture edge select |
| filt_i | input | 2xFILT_W | Per-input filter length |
| wr_i | input | 2 | Per-channel value write strobe |
| wdata_i | input | CNT_W | Write data shared by both channels |
| dual_i | input | 1 | Paired pulse-measurement mode |
| cont_i | input | 1 | 1 continuous, 0 one-shot paired capture |
| arm_i | input | 1 | Re-arm pulse for paired capture |
| clr_i | input | 2 | Per-channel flag clear |
| ie_i | input | 2 | Per-channel request enable |
| dma_en_i | input | 2 | Route request to DMA instead of interrupt |
| val_o | output | 2xCNT_W | Channel value registers |
| pin_o | output | 2 | Compare output pins |
| flag_o | output | 2 | Channel event flags |
| irq_o | output | 2 | Interrupt requests |
| dma_o | output | 2 | DMA requests |

## Verification
The hardest state to reach is a one-shot pair that has completed a measurement and is now holding. From there, further pulses on capture input 0 must leave both value registers and flags unchanged until an arm pulse arrives. The stimulus reaches this state with directed pulses of known width: it measures one pulse, sends a second pulse that must be ignored, re-arms, and measures again. Continuous mode then follows. A long randomized phase drives filter lengths, edge selections, mode changes and strobes together, so that write/capture collisions, arm pulses during a measurement, and mode switches partway through a pair all occur. A behavioural model checks every output on every clock.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
    typedef enum logic [1:0] {
        FN_OFF = 2'b00,
        FN_CMP = 2'b01,
        FN_CAP = 2'b10,
        FN_RSV = 2'b11
    } func_e;

    typedef enum logic [1:0] {
        DS_WAIT_A = 2'b00,
        DS_WAIT_B = 2'b01,
        DS_HOLD   = 2'b10
    } dual_e;

    // bit 0 qualifies rising edges, bit 1 qualifies falling edges
    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction
endpackage

// File: rtl/tcc_filt.sv
`timescale 1ns/1ps
module tcc_filt #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              rise_o,
    output logic              fall_o
);
    localparam int RW = FILT_W + 1;

    typedef struct packed {
        logic              smp;
        logic              lvl;
        logic              prv;
        logic [FILT_W-1:0] run;
    } filt_s;

    filt_s st_d, st_q;
    logic [RW-1:0] run_nx;

    always_comb begin
        st_d     = st_q;
        run_nx   = {1'b0, st_q.run} + RW'(1);
        st_d.smp = raw_i;
        st_d.prv = st_q.lvl;
        if (st_q.smp == st_q.lvl) begin
            st_d.run = '0;
        end else if ((len_i == '0) || (run_nx >= {1'b0, len_i})) begin
            st_d.lvl = st_q.smp;
            st_d.run = '0;
        end else begin
            st_d.run = run_nx[FILT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.lvl & ~st_q.prv;
    assign fall_o = ~st_q.lvl & st_q.prv;

    logic lvl_w, smp_w;
    logic [FILT_W-1:0] run_w;
    assign lvl_w = st_q.lvl;
    assign smp_w = st_q.smp;
    assign run_w = st_q.run;

    // R5
    filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_w == lvl_w) |=> $stable(lvl_w));
    // R5
    filt_first_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_i > FILT_W'(1)) && (run_w == '0) && (smp_w != lvl_w)) |=> $stable(lvl_w));
endmodule

// File: rtl/tcc_chan.sv
`timescale 1ns/1ps
module tcc_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       func_i,
    input  logic [1:0]       act_i,
    input  logic             cap_evt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_i,
    input  logic             ie_i,
    input  logic             dma_en_i,
    output logic [CNT_W-1:0] val_o,
    output logic             pin_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             dma_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             pin;
        logic             flag;
    } chan_s;

    chan_s st_d, st_q;
    logic  hit, evt;

    assign hit = (func_i == FN_CMP) && (cnt_i == st_q.val);
    assign evt = hit | cap_evt_i;

    always_comb begin
        st_d = st_q;
        if (cap_evt_i)  st_d.val = cnt_i;
        else if (wr_i)  st_d.val = wdata_i;
        if (hit) begin
            case (act_i)
                2'b01:   st_d.pin = ~st_q.pin;
                2'b10:   st_d.pin = 1'b0;
                2'b11:   st_d.pin = 1'b1;
                default: st_d.pin = st_q.pin;
            endcase
        end
        st_d.flag = evt | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign pin_o  = st_q.pin;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & ie_i & ~dma_en_i;
    assign dma_o  = st_q.flag & ie_i & dma_en_i;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_o);
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt) |=> !flag_o);
    // R3
    cap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> (val_o == $past(cnt_i)));
    // R4
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cap_evt_i) |=> (val_o == $past(wdata_i)));
    // R2
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(pin_o));
endmodule

// File: rtl/tcc_pair.sv
`timescale 1ns/1ps
module tcc_pair
    import tcc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [1:0]                 cap_i,
    input  logic [1:0][1:0]            func_i,
    input  logic [1:0][1:0]            act_i,
    input  logic [1:0][FILT_W-1:0]     filt_i,
    input  logic [1:0]                 wr_i,
    input  logic [CNT_W-1:0]           wdata_i,
    input  logic                       dual_i,
    input  logic                       cont_i,
    input  logic                       arm_i,
    input  logic [1:0]                 clr_i,
    input  logic [1:0]                 ie_i,
    input  logic [1:0]                 dma_en_i,
    output logic [1:0][CNT_W-1:0]      val_o,
    output logic [1:0]                 pin_o,
    output logic [1:0]                 flag_o,
    output logic [1:0]                 irq_o,
    output logic [1:0]                 dma_o
);
    localparam int NCH = 2;

    typedef struct packed {
        dual_e st;
    } pair_s;

    pair_s pr_d, pr_q;

    logic [NCH-1:0]      rise, fall, sgl_evt, cap_evt;
    logic [NCH-1:0][1:0] eff_func;
    logic                dua, dub;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tcc_filt #(.FILT_W(FILT_W)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (cap_i[g]),
            .len_i  (filt_i[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );

        assign sgl_evt[g]  = (func_i[g] == FN_CAP) && edge_hit(act_i[g], rise[g], fall[g]);
        assign eff_func[g] = dual_i ? FN_CAP : func_i[g];

        tcc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (cnt_i),
            .func_i    (eff_func[g]),
            .act_i     (act_i[g]),
            .cap_evt_i (cap_evt[g]),
            .wr_i      (wr_i[g]),
            .wdata_i   (wdata_i),
            .clr_i     (clr_i[g]),
            .ie_i      (ie_i[g]),
            .dma_en_i  (dma_en_i[g]),
            .val_o     (val_o[g]),
            .pin_o     (pin_o[g]),
            .flag_o    (flag_o[g]),
            .irq_o     (irq_o[g]),
            .dma_o     (dma_o[g])
        );
    end

    // paired mode: both halves look at input 0
    assign dua = (pr_q.st == DS_WAIT_A) && edge_hit(act_i[0], rise[0], fall[0]);
    assign dub = (pr_q.st == DS_WAIT_B) && edge_hit(act_i[1], rise[0], fall[0]);

    assign cap_evt[0] = dual_i ? dua : sgl_evt[0];
    assign cap_evt[1] = dual_i ? dub : sgl_evt[1];

    always_comb begin
        pr_d = pr_q;
        if (!dual_i || arm_i) begin
            pr_d.st = DS_WAIT_A;
        end else begin
            case (pr_q.st)
                DS_WAIT_A: if (dua) pr_d.st = DS_WAIT_B;
                DS_WAIT_B: if (dub) pr_d.st = cont_i ? DS_WAIT_A : DS_HOLD;
                default:   pr_d.st = DS_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '{st: DS_WAIT_A};
        else        pr_q <= pr_d;
    end

    // R9
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_i && !cont_i && !arm_i && cap_evt[1]) |=> (pr_q.st == DS_HOLD));
    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_i && (pr_q.st == DS_HOLD)) |=> ($stable(val_o) || $past(arm_i) || $past(|wr_i)));
    // R8
    dual_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_i && !arm_i && cap_evt[0]) |=> (pr_q.st == DS_WAIT_B));
endmodule

// File: tb/sim_tcc_pair.sv
`timescale 1ns/1ps
module sim_tcc_pair;
    localparam int CW = 16;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [CW-1:0]         cnt = '0;
    logic [1:0]            cap = '0;
    logic [1:0][1:0]       func = '0;
    logic [1:0][1:0]       act = '0;
    logic [1:0][FW-1:0]    filt = '0;
    logic [1:0]            wr = '0;
    logic [CW-1:0]         wdata = '0;
    logic                  dual = 1'b0, cont = 1'b0, arm = 1'b0;
    logic [1:0]            clr = '0, ie = '0, dmae = '0;
    logic [1:0][CW-1:0]    val;
    logic [1:0]            pin, flag, irq, dma;

    tcc_pair #(.CNT_W(CW), .FILT_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_i(cap), .func_i(func), .act_i(act),
        .filt_i(filt), .wr_i(wr), .wdata_i(wdata), .dual_i(dual), .cont_i(cont),
        .arm_i(arm), .clr_i(clr), .ie_i(ie), .dma_en_i(dmae), .val_o(val), .pin_o(pin),
        .flag_o(flag), .irq_o(irq), .dma_o(dma)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, a, e, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit [1:0]      m_smp, m_lvl, m_prv, m_pin, m_flag;
    int            m_run [2];
    logic [CW-1:0] m_val [2];
    int            m_st;

    function automatic bit sel_ok(input logic [1:0] s, input bit r, input bit f);
        return (s[0] && r) || (s[1] && f);
    endfunction

    always @(posedge clk) begin : model
        bit [1:0] r, f, ce, ht;
        if (!rst_n) begin
            m_smp = 0; m_lvl = 0; m_prv = 0; m_pin = 0; m_flag = 0;
            m_run[0] = 0; m_run[1] = 0; m_val[0] = 0; m_val[1] = 0; m_st = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                r[i] = m_lvl[i] && !m_prv[i];
                f[i] = !m_lvl[i] && m_prv[i];
            end
            if (dual) begin
                ce[0] = (m_st == 0) && sel_ok(act[0], r[0], f[0]);
                ce[1] = (m_st == 1) && sel_ok(act[1], r[0], f[0]);
            end else begin
                for (int i = 0; i < 2; i++) ce[i] = (func[i] == 2'b10) && sel_ok(act[i], r[i], f[i]);
            end
            for (int i = 0; i < 2; i++) ht[i] = !dual && (func[i] == 2'b01) && (cnt == m_val[i]);
            for (int i = 0; i < 2; i++) begin
                m_flag[i] = ht[i] || ce[i] || (m_flag[i] && !clr[i]);
                if (ce[i]) m_val[i] = cnt;
                else if (wr[i]) m_val[i] = wdata;
                if (ht[i]) begin
                    if (act[i] == 2'b01) m_pin[i] = !m_pin[i];
                    else if (act[i] == 2'b10) m_pin[i] = 0;
                    else if (act[i] == 2'b11) m_pin[i] = 1;
                end
            end
            if (!dual || arm) m_st = 0;
            else if (m_st == 0 && ce[0]) m_st = 1;
            else if (m_st == 1 && ce[1]) m_st = cont ? 0 : 2;
            for (int i = 0; i < 2; i++) begin
                m_prv[i] = m_lvl[i];
                if (m_smp[i] == m_lvl[i]) m_run[i] = 0;
                else if (filt[i] == 0 || m_run[i] + 1 >= int'(filt[i])) begin
                    m_lvl[i] = m_smp[i]; m_run[i] = 0;
                end else m_run[i] = m_run[i] + 1;
                m_smp[i] = cap[i];
            end
        end
    end

    // cycle-by-cycle comparison
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                chk(val[i] == m_val[i], "R3/R4", $sformatf("val[%0d]", i), int'(val[i]), int'(m_val[i]));
                chk(pin[i] == m_pin[i], "R2", $sformatf("pin[%0d]", i), pin[i], m_pin[i]);
                chk(flag[i] == m_flag[i], "R6", $sformatf("flag[%0d]", i), flag[i], m_flag[i]);
                chk(irq[i] == (m_flag[i] & ie[i] & ~dmae[i]), "R7", $sformatf("irq[%0d]", i),
                    irq[i], m_flag[i] & ie[i] & ~dmae[i]);
                chk(dma[i] == (m_flag[i] & ie[i] & dmae[i]), "R7", $sformatf("dma[%0d]", i),
                    dma[i], m_flag[i] & ie[i] & dmae[i]);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            cnt = cnt + 1'b1;
        end
    endtask

    task automatic pulse0(input int w, input int gap);
        cap[0] = 1'b1; tick(w);
        cap[0] = 1'b0; tick(gap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        chk(val[0] == 0 && val[1] == 0, "R1", "values after reset", int'(val[0]), 0);
        chk(pin == 0 && flag == 0 && irq == 0 && dma == 0, "R1", "outputs after reset",
            int'({pin, flag, irq, dma}), 0);

        // R2 compare: toggle on ch0, set on ch1
        func[0] = 2'b01; func[1] = 2'b01; act[0] = 2'b01; act[1] = 2'b11;
        ie = 2'b11; dmae = 2'b10;
        wr = 2'b01; wdata = cnt + 16'd12; tick(1);
        wr = 2'b10; wdata = cnt + 16'd20; tick(1);
        wr = 2'b00; tick(25);
        chk(pin[0] == 1'b1, "R2", "toggle after match", pin[0], 1);
        chk(pin[1] == 1'b1, "R2", "set after match", pin[1], 1);
        chk(irq[0] && dma[1] && !irq[1] && !dma[0], "R7", "routing", int'({irq, dma}), 'b0110);
        clr = 2'b11; tick(1); clr = 2'b00;
        act[0] = 2'b10; act[1] = 2'b00;
        wr = 2'b11; wdata = cnt + 16'd8; tick(1); wr = 2'b00; tick(12);
        chk(pin[0] == 1'b0, "R2", "clear after match", pin[0], 0);
        chk(pin[1] == 1'b1 && flag[1], "R2", "no-change action keeps pin, sets flag", pin[1], 1);
        clr = 2'b11; tick(1); clr = 2'b00;

        // R3 single-edge capture
        func[0] = 2'b10; func[1] = 2'b10; act[0] = 2'b01; act[1] = 2'b11;
        cap = 2'b11; tick(6); cap = 2'b00; tick(6); cap = 2'b10; tick(5); cap = 2'b00; tick(5);
        chk(flag == 2'b11, "R3", "capture flags", flag, 3);

        // R5 filter glitch suppression
        clr = 2'b11; tick(1); clr = 2'b00;
        filt[0] = 4'd3; act[0] = 2'b11;
        pulse0(2, 8);
        chk(flag[0] == 1'b0, "R5", "short glitch ignored", flag[0], 0);
        pulse0(6, 8);
        chk(flag[0] == 1'b1, "R5", "long pulse accepted", flag[0], 1);
        filt[0] = 4'd0;

        // R8/R9 paired one-shot then continuous
        dual = 1'b1; cont = 1'b0; act[0] = 2'b01; act[1] = 2'b10; func = '0;
        arm = 1'b1; tick(1); arm = 1'b0; tick(2);
        pulse0(5, 6);
        chk(int'(val[1] - val[0]) == 5, "R8", "pulse width 5", int'(val[1] - val[0]), 5);
        begin
            logic [CW-1:0] k0, k1;
            k0 = val[0]; k1 = val[1];
            cap[1] = 1'b1;
            pulse0(3, 6);
            cap[1] = 1'b0;
            chk(val[0] == k0 && val[1] == k1, "R9", "one-shot holds", int'(val[0]), int'(k0));
        end
        arm = 1'b1; tick(1); arm = 1'b0; tick(2);
        pulse0(4, 6);
        chk(int'(val[1] - val[0]) == 4, "R9", "re-armed width 4", int'(val[1] - val[0]), 4);
        cont = 1'b1; arm = 1'b1; tick(1); arm = 1'b0; tick(2);
        pulse0(3, 6);
        chk(int'(val[1] - val[0]) == 3, "R9", "continuous width 3", int'(val[1] - val[0]), 3);
        pulse0(7, 6);
        chk(int'(val[1] - val[0]) == 7, "R9", "continuous width 7", int'(val[1] - val[0]), 7);

        // mixed stimulus, R4 collisions included
        for (int c = 0; c < 2500; c++) begin
            if (c % 64 == 0) begin
                func = 4'($urandom); act = 4'($urandom);
                filt[0] = FW'($urandom % 4); filt[1] = FW'($urandom % 4);
                dual = ($urandom % 3 == 0); cont = 1'($urandom);
            end
            if ($urandom % 4 == 0) cap = 2'($urandom);
            wr = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
            wdata = cnt + 16'($urandom % 12);
            clr[0] = ($urandom % 5 == 0); clr[1] = ($urandom % 5 == 0);
            ie = 2'($urandom); dmae = 2'($urandom);
            arm = ($urandom % 20 == 0);
            tick(1);
        end
        wr = '0; clr = '0; arm = 1'b0;
        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule